// File: doc/BRIEF.md
# Ring Node Router with Pass, Read and Write Modes

This block is the per-node router of a one-way ring of processing nodes. Each node has one link from its upstream neighbour, one link to its downstream neighbour and a local processor port. A word that arrives from upstream is held in a single-word holding register. Its top bits name a target node. If the target is this node, the word waits there until the local processor reads it. If the target is any other node, the word goes on downstream without the processor taking part.

The local processor can also inject a word of its own onto the downstream link. Forwarded traffic and injected traffic both need the one output driver. When both want it, an age-based arbiter decides which goes first. While a word waits in the holding register, the upstream link is stalled. This blocking is the interference that other nodes on the ring observe.

Every port uses a four-phase request/acknowledge handshake. Reset is active-low and asynchronous.

Top module: `ring_router`

## Requirements
- R1: While reset is active and right after it is released, `lnk_in_ack_o`, `lnk_out_req_o`, `cpu_rd_ack_o` and `cpu_wr_ack_o` are all low.
- R2: A received word whose bits [DATA_W-1 -: ID_W] differ from `node_id_i` is sent on the output link unchanged, and `cpu_rd_ack_o` stays low for it.
- R3: A received word whose bits [DATA_W-1 -: ID_W] equal `node_id_i` is never driven on the output link. It is returned on `cpu_rdata_o` with `cpu_rd_ack_o` high in answer to `cpu_rd_req_i`.
- R4: A processor write puts `cpu_wdata_i` on the output link. `cpu_wr_ack_o` rises only after the output handshake has seen `lnk_out_ack_i` high, and it stays high until `cpu_wr_req_i` falls.
- R5: Once `lnk_out_req_o` is high, it and `lnk_out_data_o` hold until `lnk_out_ack_i` is high. `lnk_out_req_o` then falls, and it does not rise again while `lnk_out_ack_i` is still high.
- R6: `lnk_in_ack_o` rises only after `lnk_in_req_i` has been seen high and the word has been captured. It stays high until `lnk_in_req_i` falls. No new word is acknowledged while the holding register is full.
- R7: The holding register becomes free again after its word completes an output handshake or a processor read handshake, and the next incoming word is then acknowledged.
- R8: When forwarded and injected words both wait for the idle output link, the one that has waited more cycles is sent first.
- R9: When both have waited the same number of cycles, the forwarded word is sent first.
- R10: A processor read request with no word addressed to this node in the holding register is not acknowledged. This holds both when the register is empty and when it holds a word for another node.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_id_i | input | ID_W | Identity of this node |
| lnk_in_req_i | input | 1 | Upstream link request |
| lnk_in_ack_o | output | 1 | Upstream link acknowledge |
| lnk_in_data_i | input | DATA_W | Upstream link word |
| lnk_out_req_o | output | 1 | Downstream link request |
| lnk_out_ack_i | input | 1 | Downstream link acknowledge |
| lnk_out_data_o | output | DATA_W | Downstream link word |
| cpu_rd_req_i | input | 1 | Processor read request |
| cpu_rd_ack_o | output | 1 | Processor read acknowledge |
| cpu_rdata_o | output | DATA_W | Word delivered to the processor |
| cpu_wr_req_i | input | 1 | Processor write request |
| cpu_wr_ack_o | output | 1 | Processor write acknowledge |
| cpu_wdata_i | input | DATA_W | Word supplied by the processor |

## Verification
The steering logic is tried with words addressed to other nodes and words addressed to this node. The first kind shows that forwarding happens without the processor, and the second shows that local words never leak onto the output link. A second incoming word offered while a local word is still unread shows the blocking of the upstream link and its release by a read. Two contention patterns separate the arbitration rules. In one, a forwarded word and a write arrive on consecutive cycles, which gives equal ages and must favour forwarding. In the other, a write is made to wait behind a long output transfer while a fresh forwarded word arrives, which must favour the older write. A plain fixed-priority arbiter fails that second pattern.

// File: rtl/ring_router_pkg.sv
package ring_router_pkg;
  typedef enum logic [1:0] {DRV_IDLE, DRV_REQ, DRV_REL} drv_state_e;
  typedef enum logic {SRC_PASS, SRC_WRITE} src_e;
endpackage

// File: rtl/rr_in_latch.sv
module rr_in_latch #(
  parameter int DATA_W = 16,
  parameter int ID_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   node_id_i,
  input  logic              in_req_i,
  output logic              in_ack_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              clr_i,
  output logic              valid_o,
  output logic              local_o,
  output logic [DATA_W-1:0] word_o
);
  logic              valid_q, ack_q;
  logic [DATA_W-1:0] word_q;
  logic              accept;

  assign accept = in_req_i & ~ack_q & ~valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ack_q   <= 1'b0;
      word_q  <= '0;
    end else begin
      if (accept) begin
        word_q <= in_data_i;
        ack_q  <= 1'b1;
      end else if (ack_q && !in_req_i) begin
        ack_q <= 1'b0;
      end
      if (clr_i)       valid_q <= 1'b0;
      else if (accept) valid_q <= 1'b1;
    end
  end

  assign in_ack_o = ack_q;
  assign valid_o  = valid_q;
  assign word_o   = word_q;
  assign local_o  = (word_q[DATA_W-1 -: ID_W] == node_id_i);
endmodule

// File: rtl/rr_cpu_rd.sv
module rr_cpu_rd #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_req_i,
  input  logic              avail_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              rd_ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              take_o
);
  logic              ack_q;
  logic [DATA_W-1:0] data_q;

  assign take_o = rd_req_i & ~ack_q & avail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      data_q <= '0;
    end else if (take_o) begin
      ack_q  <= 1'b1;
      data_q <= word_i;
    end else if (!rd_req_i) begin
      ack_q <= 1'b0;
    end
  end

  assign rd_ack_o = ack_q;
  assign rdata_o  = data_q;
endmodule

// File: rtl/rr_age_arb.sv
module rr_age_arb #(
  parameter int AGE_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  input  logic pass_req_i,
  input  logic wr_req_i,
  output logic gnt_pass_o,
  output logic gnt_wr_o
);
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  logic [AGE_W-1:0] age_q [2];
  logic [1:0]       req, gnt;
  logic             pass_first;

  assign req        = {wr_req_i, pass_req_i};
  // older wins, tie goes to pass traffic
  assign pass_first = pass_req_i & (~wr_req_i | (age_q[0] >= age_q[1]));
  assign gnt[0]     = idle_i & pass_first;
  assign gnt[1]     = idle_i & wr_req_i & ~pass_first;

  for (genvar g = 0; g < 2; g++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  age_q[g] <= '0;
      else if (!req[g] || gnt[g])   age_q[g] <= '0;
      else if (age_q[g] != AGE_MAX) age_q[g] <= age_q[g] + 1'b1;
    end
  end

  assign gnt_pass_o = gnt[0];
  assign gnt_wr_o   = gnt[1];
endmodule

// File: rtl/rr_out_drv.sv
module rr_out_drv
  import ring_router_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gnt_pass_i,
  input  logic              gnt_wr_i,
  input  logic [DATA_W-1:0] pass_word_i,
  input  logic [DATA_W-1:0] wr_word_i,
  input  logic              wr_req_i,
  input  logic              out_ack_i,
  output logic              out_req_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              idle_o,
  output src_e              src_o,
  output logic              done_pass_o,
  output logic              wr_ack_o
);
  drv_state_e        state_q;
  src_e              src_q;
  logic [DATA_W-1:0] data_q;
  logic              wr_ack_q, done;

  assign done = (state_q == DRV_REQ) & out_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DRV_IDLE;
      src_q   <= SRC_PASS;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        DRV_IDLE: if (gnt_pass_i || gnt_wr_i) begin
          data_q  <= gnt_pass_i ? pass_word_i : wr_word_i;
          src_q   <= gnt_pass_i ? SRC_PASS : SRC_WRITE;
          state_q <= DRV_REQ;
        end
        DRV_REQ:  if (out_ack_i)  state_q <= DRV_REL;
        DRV_REL:  if (!out_ack_i) state_q <= DRV_IDLE;
        default:  state_q <= DRV_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         wr_ack_q <= 1'b0;
    else if (done && src_q == SRC_WRITE) wr_ack_q <= 1'b1;
    else if (!wr_req_i)                  wr_ack_q <= 1'b0;
  end

  assign out_req_o   = (state_q == DRV_REQ);
  assign out_data_o  = data_q;
  assign idle_o      = (state_q == DRV_IDLE);
  assign src_o       = src_q;
  assign done_pass_o = done & (src_q == SRC_PASS);
  assign wr_ack_o    = wr_ack_q;
endmodule

// File: rtl/ring_router.sv
module ring_router
  import ring_router_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ID_W   = 3,
  parameter int AGE_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   node_id_i,
  input  logic              lnk_in_req_i,
  output logic              lnk_in_ack_o,
  input  logic [DATA_W-1:0] lnk_in_data_i,
  output logic              lnk_out_req_o,
  input  logic              lnk_out_ack_i,
  output logic [DATA_W-1:0] lnk_out_data_o,
  input  logic              cpu_rd_req_i,
  output logic              cpu_rd_ack_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              cpu_wr_req_i,
  output logic              cpu_wr_ack_o,
  input  logic [DATA_W-1:0] cpu_wdata_i
);
  logic              valid, is_local, clr, take_rd, done_pass;
  logic              drv_idle, pass_req, wr_pend, gnt_pass, gnt_wr;
  logic [DATA_W-1:0] held_word;
  src_e              drv_src;

  assign clr = take_rd | done_pass;

  rr_in_latch #(.DATA_W(DATA_W), .ID_W(ID_W)) i_latch (
    .clk_i, .rst_ni, .node_id_i,
    .in_req_i (lnk_in_req_i),
    .in_ack_o (lnk_in_ack_o),
    .in_data_i(lnk_in_data_i),
    .clr_i    (clr),
    .valid_o  (valid),
    .local_o  (is_local),
    .word_o   (held_word)
  );

  rr_cpu_rd #(.DATA_W(DATA_W)) i_rd (
    .clk_i, .rst_ni,
    .rd_req_i(cpu_rd_req_i),
    .avail_i (valid & is_local),
    .word_i  (held_word),
    .rd_ack_o(cpu_rd_ack_o),
    .rdata_o (cpu_rdata_o),
    .take_o  (take_rd)
  );

  // a request already owning the driver does not compete again
  assign pass_req = valid & ~is_local & ~(~drv_idle & (drv_src == SRC_PASS));
  assign wr_pend  = cpu_wr_req_i & ~cpu_wr_ack_o & ~(~drv_idle & (drv_src == SRC_WRITE));

  rr_age_arb #(.AGE_W(AGE_W)) i_arb (
    .clk_i, .rst_ni,
    .idle_i    (drv_idle),
    .pass_req_i(pass_req),
    .wr_req_i  (wr_pend),
    .gnt_pass_o(gnt_pass),
    .gnt_wr_o  (gnt_wr)
  );

  rr_out_drv #(.DATA_W(DATA_W)) i_drv (
    .clk_i, .rst_ni,
    .gnt_pass_i (gnt_pass),
    .gnt_wr_i   (gnt_wr),
    .pass_word_i(held_word),
    .wr_word_i  (cpu_wdata_i),
    .wr_req_i   (cpu_wr_req_i),
    .out_ack_i  (lnk_out_ack_i),
    .out_req_o  (lnk_out_req_o),
    .out_data_o (lnk_out_data_o),
    .idle_o     (drv_idle),
    .src_o      (drv_src),
    .done_pass_o(done_pass),
    .wr_ack_o   (cpu_wr_ack_o)
  );
endmodule

// File: rtl/ring_router_chk.sv
module ring_router_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_req,
  input logic              in_ack,
  input logic              out_req,
  input logic              out_ack,
  input logic [DATA_W-1:0] out_data,
  input logic              rd_req,
  input logic              rd_ack,
  input logic              wr_req,
  input logic              wr_ack
);
  // R5
  out_req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_req && !out_ack |=> out_req);
  // R5
  out_data_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_req && !out_ack |=> $stable(out_data));
  // R5
  out_no_rerequest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_req && out_ack |=> !out_req);
  // R6
  in_ack_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_ack) |-> $past(in_req));
  // R6
  in_ack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ack && in_req |=> in_ack);
  // R4
  wr_ack_after_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_ack) |-> $past(out_req && out_ack));
  // R4
  wr_ack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ack && wr_req |=> wr_ack);
  // R3
  rd_ack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack && rd_req |=> rd_ack);
  // R10
  rd_ack_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_ack) |-> $past(rd_req));
endmodule

bind ring_router ring_router_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .in_req  (lnk_in_req_i),
  .in_ack  (lnk_in_ack_o),
  .out_req (lnk_out_req_o),
  .out_ack (lnk_out_ack_i),
  .out_data(lnk_out_data_o),
  .rd_req  (cpu_rd_req_i),
  .rd_ack  (cpu_rd_ack_o),
  .wr_req  (cpu_wr_req_i),
  .wr_ack  (cpu_wr_ack_o)
);

// File: tb/test_ring_router.sv
`timescale 1ns/1ps
module test_ring_router;
  localparam int DW = 16;
  localparam int IW = 3;
  localparam logic [IW-1:0] ME = 3'd5;

  localparam int S_IN_ACK  = 0;
  localparam int S_OUT_REQ = 1;
  localparam int S_RD_ACK  = 2;
  localparam int S_WR_ACK  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_req = 0, out_ack = 0, rd_req = 0, wr_req = 0;
  logic [DW-1:0] in_data = '0, wdata = '0;
  logic in_ack, out_req, rd_ack, wr_ack;
  logic [DW-1:0] out_data, rdata;

  int n_chk = 0, n_fail = 0, out_rise = 0;
  logic out_prev = 1'b0;

  always #2.5 clk = ~clk;

  ring_router #(.DATA_W(DW), .ID_W(IW), .AGE_W(4)) i_ring_router (
    .clk_i(clk), .rst_ni(rst_n), .node_id_i(ME),
    .lnk_in_req_i(in_req), .lnk_in_ack_o(in_ack), .lnk_in_data_i(in_data),
    .lnk_out_req_o(out_req), .lnk_out_ack_i(out_ack), .lnk_out_data_o(out_data),
    .cpu_rd_req_i(rd_req), .cpu_rd_ack_o(rd_ack), .cpu_rdata_o(rdata),
    .cpu_wr_req_i(wr_req), .cpu_wr_ack_o(wr_ack), .cpu_wdata_i(wdata)
  );

  always @(negedge clk) begin
    if (out_req && !out_prev) out_rise++;
    out_prev = out_req;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic probe(input int sel);
    case (sel)
      S_IN_ACK:  return in_ack;
      S_OUT_REQ: return out_req;
      S_RD_ACK:  return rd_ack;
      default:   return wr_ack;
    endcase
  endfunction

  task automatic wait_for(input int sel, input logic val, input string req);
    bit ok = 0;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (probe(sel) === val) begin ok = 1; break; end
    end
    chk(req, {31'd0, ok}, 32'd1);
  endtask

  task automatic send_word(input logic [DW-1:0] w, input string req);
    @(negedge clk);
    in_data = w; in_req = 1'b1;
    wait_for(S_IN_ACK, 1'b1, req);
    in_req = 1'b0;
    wait_for(S_IN_ACK, 1'b0, req);
  endtask

  task automatic out_grab(input logic [DW-1:0] exp, input string req, input int hold);
    wait_for(S_OUT_REQ, 1'b1, req);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R5", {31'd0, out_req}, 32'd1);
      chk("R5", {16'd0, out_data}, {16'd0, exp});
    end
    chk(req, {16'd0, out_data}, {16'd0, exp});
    out_ack = 1'b1;
    wait_for(S_OUT_REQ, 1'b0, "R5");
  endtask

  task automatic out_drop();
    out_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic cpu_read(input logic [DW-1:0] exp, input string req);
    rd_req = 1'b1;
    wait_for(S_RD_ACK, 1'b1, req);
    chk(req, {16'd0, rdata}, {16'd0, exp});
    rd_req = 1'b0;
    wait_for(S_RD_ACK, 1'b0, req);
  endtask

  task automatic wr_finish(input string req);
    wait_for(S_WR_ACK, 1'b1, req);
    wr_req = 1'b0;
    wait_for(S_WR_ACK, 1'b0, req);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", {28'd0, in_ack, out_req, rd_ack, wr_ack}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {28'd0, in_ack, out_req, rd_ack, wr_ack}, 32'd0);
  endtask

  task automatic t_pass();
    send_word(16'h4abc, "R6");
    chk("R2", {31'd0, rd_ack}, 32'd0);
    out_grab(16'h4abc, "R2", 3);
    out_drop();
  endtask

  task automatic t_read();
    int r0 = out_rise;
    send_word(16'ha123, "R6");
    repeat (8) @(negedge clk);
    chk("R3", out_rise, r0);
    cpu_read(16'ha123, "R3");
    chk("R3", out_rise, r0);
  endtask

  task automatic t_block();
    send_word(16'ha055, "R6");
    @(negedge clk);
    in_data = 16'he777; in_req = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R6", {31'd0, in_ack}, 32'd0);
    end
    cpu_read(16'ha055, "R3");
    wait_for(S_IN_ACK, 1'b1, "R7");
    in_req = 1'b0;
    wait_for(S_IN_ACK, 1'b0, "R6");
    out_grab(16'he777, "R7", 0);
    out_drop();
  endtask

  task automatic t_write();
    @(negedge clk);
    wdata = 16'h2468; wr_req = 1'b1;
    wait_for(S_OUT_REQ, 1'b1, "R4");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R4", {31'd0, wr_ack}, 32'd0);
    end
    chk("R4", {16'd0, out_data}, 32'h2468);
    out_ack = 1'b1;
    wait_for(S_WR_ACK, 1'b1, "R4");
    chk("R4", {31'd0, out_req}, 32'd0);
    out_drop();
    repeat (3) @(negedge clk);
    chk("R4", {31'd0, wr_ack}, 32'd1);
    wr_req = 1'b0;
    wait_for(S_WR_ACK, 1'b0, "R4");
  endtask

  task automatic t_tie();
    @(negedge clk);
    in_data = 16'h0111; in_req = 1'b1;
    @(negedge clk);
    wdata = 16'h6222; wr_req = 1'b1;
    chk("R6", {31'd0, in_ack}, 32'd1);
    in_req = 1'b0;
    out_grab(16'h0111, "R9", 0);
    out_drop();
    out_grab(16'h6222, "R9", 0);
    out_drop();
    wr_finish("R4");
  endtask

  task automatic t_age();
    send_word(16'h2301, "R6");
    wait_for(S_OUT_REQ, 1'b1, "R2");
    wdata = 16'hc404; wr_req = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2", {16'd0, out_data}, 32'h2301);
    out_ack = 1'b1;
    wait_for(S_OUT_REQ, 1'b0, "R5");
    send_word(16'h4505, "R7");
    chk("R5", {31'd0, out_req}, 32'd0);
    out_drop();
    out_grab(16'hc404, "R8", 0);
    out_drop();
    wr_finish("R4");
    out_grab(16'h4505, "R8", 0);
    out_drop();
  endtask

  task automatic t_rd_wait();
    @(negedge clk);
    rd_req = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R10", {31'd0, rd_ack}, 32'd0);
    end
    out_ack = 1'b0;
    send_word(16'he909, "R6");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10", {31'd0, rd_ack}, 32'd0);
    end
    rd_req = 1'b0;
    out_grab(16'he909, "R2", 0);
    out_drop();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_pass();
    t_read();
    t_block();
    t_write();
    t_tie();
    t_age();
    t_rd_wait();
    repeat (4) @(negedge clk);
    summary();
  end
endmodule